// File: doc/BRIEF.md
# Internal Oscillator Postscaler Selector

This block turns a fast on-chip oscillator clock (8 MHz nominal) into one selectable device clock. A 3-bit frequency code picks between the undivided oscillator and the taps of a binary divider chain. At the slowest code, a source bit chooses between the fast oscillator divided by 256 (31.25 kHz) and an independent low-power RC clock (about 31 kHz). The RC clock is also sent unchanged to a separate always-on output, which feeds watchdog and clock-monitor logic.

The code and the source bit are loaded together through a one-cycle write strobe and take effect on the next oscillator edge. Any reset returns the code to the 1 MHz setting and clears the source bit. Retuning of the oscillator and glitch-free handover of the system clock happen elsewhere.

Top module: `osc_postscaler_sel`

## Requirements
- R1: The frequency code selects the output clock as follows, with an 8 MHz input: 111 = 8 MHz (the input itself), 110 = 4 MHz, 101 = 2 MHz, 100 = 1 MHz, 011 = 500 kHz, 010 = 250 kHz, 001 = 125 kHz.
- R2: When `cfg_wr` is high at a rising edge of `clk_osc`, `cfg_code` and `cfg_src` are loaded at that edge, and `clk_out` follows the new setting from then on. When `cfg_wr` is low, the stored setting does not change.
- R3: A synchronous reset (`rst` high at an edge of `clk_osc`) sets the code to 100 (1 MHz) and the source bit to 0.
- R4: With code 000, source bit 1 selects the oscillator divided by 256 (31.25 kHz), and source bit 0 selects `clk_rc`.
- R5: `clk_aon` always equals `clk_rc`, whatever the code and the source bit are.
- R6: Every divided output comes from a free-running counter that advances by one on each oscillator edge, so it has a 50% duty cycle.
- R7: The source bit has no effect for any code other than 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Fast internal oscillator clock (8 MHz nominal) |
| clk_rc | input | 1 | Independent low-power RC clock (about 31 kHz) |
| rst | input | 1 | Synchronous active-high reset, sampled on clk_osc |
| cfg_wr | input | 1 | Write strobe for the code and the source bit |
| cfg_code | input | 3 | New frequency code |
| cfg_src | input | 1 | New source bit for code 000 |
| clk_out | output | 1 | Selected internal clock |
| clk_aon | output | 1 | Always-on RC clock for watchdog and monitor logic |

## Verification
Four properties are checked on every oscillator cycle:
- the code and source bit load on a write strobe and hold their value without one;
- reset returns the code and source bit to their defaults;
- the divider counter advances by exactly one per cycle.

The frequency of each code, the duty cycle, and the behaviour of the source bit at code 000 and at the other codes can only be shown at the output pins. The bench therefore measures periods and high times there for every setting. It also measures the period just after a code change in the middle of a run, and the period of the always-on output under different settings.

// File: rtl/osc_postscaler_pkg.sv
package osc_postscaler_pkg;

    localparam int SEL_W    = 3;
    localparam int DIV_BITS = 8;
    localparam int NUM_SEL  = 1 << SEL_W;

    typedef enum logic [SEL_W-1:0] {
        SEL_LOWEST = 3'b000,
        SEL_DIV64  = 3'b001,
        SEL_DIV32  = 3'b010,
        SEL_DIV16  = 3'b011,
        SEL_DIV8   = 3'b100,
        SEL_DIV4   = 3'b101,
        SEL_DIV2   = 3'b110,
        SEL_FULL   = 3'b111
    } freq_sel_e;

    typedef struct packed {
        freq_sel_e code;
        logic      src;
    } clk_cfg_t;

    localparam clk_cfg_t CFG_RESET = '{code: SEL_DIV8, src: 1'b0};

    // Counter bit that produces the divided clock for a middle code.
    function automatic int tap_bit(input int code);
        return (NUM_SEL - 2) - code;
    endfunction

endpackage

// File: rtl/osc_cfg_reg.sv
module osc_cfg_reg
    import osc_postscaler_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [SEL_W-1:0] wr_code,
    input  logic             wr_src,
    output clk_cfg_t         cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (wr) begin
            cfg.code <= freq_sel_e'(wr_code);
            cfg.src  <= wr_src;
        end
    end

endmodule

// File: rtl/osc_div_chain.sv
module osc_div_chain #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    output logic [WIDTH-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/osc_clk_mux.sv
module osc_clk_mux
    import osc_postscaler_pkg::*;
#(
    parameter int WIDTH = DIV_BITS
) (
    input  logic             clk_fast,
    input  logic             clk_slow,
    input  logic [WIDTH-1:0] div_count,
    input  clk_cfg_t         cfg,
    output logic             clk_sel
);

    logic [NUM_SEL-1:0] taps;

    // The slowest code chooses between the top counter bit and the RC clock.
    assign taps[0]         = cfg.src ? div_count[WIDTH-1] : clk_slow;
    assign taps[NUM_SEL-1] = clk_fast;

    for (genvar c = 1; c < NUM_SEL - 1; c++) begin : g_tap
        assign taps[c] = div_count[tap_bit(c)];
    end

    assign clk_sel = taps[cfg.code];

endmodule

// File: rtl/osc_postscaler_sel.sv
module osc_postscaler_sel
    import osc_postscaler_pkg::*;
(
    input  logic             clk_osc,
    input  logic             clk_rc,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [SEL_W-1:0] cfg_code,
    input  logic             cfg_src,
    output logic             clk_out,
    output logic             clk_aon
);

    clk_cfg_t            cfg_q;
    logic [DIV_BITS-1:0] div_cnt;

    osc_cfg_reg u_cfg (
        .clk     (clk_osc),
        .rst     (rst),
        .wr      (cfg_wr),
        .wr_code (cfg_code),
        .wr_src  (cfg_src),
        .cfg     (cfg_q)
    );

    osc_div_chain #(.WIDTH(DIV_BITS)) u_div (
        .clk   (clk_osc),
        .rst   (rst),
        .count (div_cnt)
    );

    osc_clk_mux #(.WIDTH(DIV_BITS)) u_mux (
        .clk_fast  (clk_osc),
        .clk_slow  (clk_rc),
        .div_count (div_cnt),
        .cfg       (cfg_q),
        .clk_sel   (clk_out)
    );

    assign clk_aon = clk_rc;

endmodule

// File: rtl/osc_postscaler_sel_chk.sv
module osc_postscaler_sel_chk
    import osc_postscaler_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                wr,
    input logic [SEL_W-1:0]    wr_code,
    input logic                wr_src,
    input logic [SEL_W-1:0]    code_q,
    input logic                src_q,
    input logic [DIV_BITS-1:0] cnt
);

    assert_cfg_load_R2: assert property (@(posedge clk) disable iff (rst)
        wr |=> (code_q == $past(wr_code)) && (src_q == $past(wr_src)));

    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(code_q) && $stable(src_q));

    assert_reset_default_R3: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (code_q == 3'b100) && !src_q);

    assert_counter_step_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> cnt == $past(cnt) + 1'b1);

endmodule

bind osc_postscaler_sel osc_postscaler_sel_chk u_chk (
    .clk     (clk_osc),
    .rst     (rst),
    .wr      (cfg_wr),
    .wr_code (cfg_code),
    .wr_src  (cfg_src),
    .code_q  (cfg_q.code),
    .src_q   (cfg_q.src),
    .cnt     (div_cnt)
);

// File: tb/osc_postscaler_sel_tb.sv
`timescale 1ns/1ps
module osc_postscaler_sel_tb;

    localparam int OSC_HALF = 5;    // 100 MHz bench clock stands in for the oscillator
    localparam int RC_HALF  = 165;  // RC period 330 ns, unrelated to any tap

    typedef struct {
        int    exp_per;
        bit    aon;
        int    skip;
        string tag;
    } item_t;

    logic       clk_osc = 1'b0;
    logic       clk_rc  = 1'b0;
    logic       rst     = 1'b1;
    logic       cfg_wr  = 1'b0;
    logic [2:0] cfg_code = 3'b000;
    logic       cfg_src  = 1'b0;
    logic       clk_out;
    logic       clk_aon;

    int    checks   = 0;
    int    failures = 0;
    item_t exp_q[$];
    bit    req = 1'b0;
    bit    finished = 1'b0;

    always #(OSC_HALF) clk_osc = ~clk_osc;
    always #(RC_HALF)  clk_rc  = ~clk_rc;

    osc_postscaler_sel u_dut (
        .clk_osc  (clk_osc),
        .clk_rc   (clk_rc),
        .rst      (rst),
        .cfg_wr   (cfg_wr),
        .cfg_code (cfg_code),
        .cfg_src  (cfg_src),
        .clk_out  (clk_out),
        .clk_aon  (clk_aon)
    );

    // Monitor: measures period and high time, then compares against the queue.
    initial begin
        forever begin
            item_t it;
            realtime t0, t1, t2;
            int per, hi;
            wait (req);
            it = exp_q.pop_front();
            if (it.aon) begin
                for (int i = 0; i < it.skip; i++) @(posedge clk_aon);
                @(posedge clk_aon); t0 = $realtime;
                @(negedge clk_aon); t1 = $realtime;
                @(posedge clk_aon); t2 = $realtime;
            end else begin
                for (int i = 0; i < it.skip; i++) @(posedge clk_out);
                @(posedge clk_out); t0 = $realtime;
                @(negedge clk_out); t1 = $realtime;
                @(posedge clk_out); t2 = $realtime;
            end
            per = $rtoi(t2 - t0 + 0.5);
            hi  = $rtoi(t1 - t0 + 0.5);
            checks++;
            if (per != it.exp_per) begin
                failures++;
                $display("FAIL %s period actual=%0d expected=%0d", it.tag, per, it.exp_per);
            end
            checks++;
            if (hi * 2 != it.exp_per) begin
                failures++;
                $display("FAIL %s/R6 high time actual=%0d expected=%0d", it.tag, hi, it.exp_per / 2);
            end
            req = 1'b0;
        end
    end

    task automatic write_cfg(input logic [2:0] code, input logic src);
        @(negedge clk_osc);
        cfg_wr   = 1'b1;
        cfg_code = code;
        cfg_src  = src;
        @(negedge clk_osc);
        cfg_wr   = 1'b0;
    endtask

    task automatic expect_period(input int per, input bit aon, input int skip, input string tag);
        item_t it;
        it.exp_per = per;
        it.aon     = aon;
        it.skip    = skip;
        it.tag     = tag;
        exp_q.push_back(it);
        req = 1'b1;
        wait (!req);
    endtask

    initial begin
        repeat (4) @(negedge clk_osc);
        rst = 1'b0;
        // R3: after reset the output runs at 1 MHz (period 8 oscillator cycles)
        expect_period(80, 1'b0, 1, "R3");
        // R5: always-on clock equals the RC clock
        expect_period(2 * RC_HALF, 1'b1, 0, "R5");

        // R1: every middle code, source bit 0
        for (int c = 7; c >= 1; c--) begin
            write_cfg(3'(c), 1'b0);
            expect_period(10 << (7 - c), 1'b0, 1, "R1");
        end
        // R7: source bit set has no effect on the middle codes
        for (int c = 7; c >= 1; c -= 3) begin
            write_cfg(3'(c), 1'b1);
            expect_period(10 << (7 - c), 1'b0, 1, "R7");
        end

        // R4: code 000 with source bit 1 gives osc/256, with 0 gives the RC clock
        write_cfg(3'b000, 1'b1);
        expect_period(2560, 1'b0, 1, "R4");
        expect_period(2 * RC_HALF, 1'b1, 0, "R5");
        write_cfg(3'b000, 1'b0);
        expect_period(2 * RC_HALF, 1'b0, 1, "R4");

        // R2: change in mid-run, the new rate appears right after the write
        write_cfg(3'b100, 1'b0);
        expect_period(80, 1'b0, 1, "R2");
        write_cfg(3'b111, 1'b0);
        expect_period(10, 1'b0, 1, "R2");
        write_cfg(3'b011, 1'b1);
        expect_period(160, 1'b0, 1, "R2");

        // R2: no strobe, so data lines alone must not alter the rate
        @(negedge clk_osc);
        cfg_code = 3'b111;
        cfg_src  = 1'b0;
        repeat (3) @(negedge clk_osc);
        expect_period(160, 1'b0, 1, "R2");

        // R3: reset in mid-run restores the default rate
        @(negedge clk_osc);
        rst = 1'b1;
        repeat (2) @(negedge clk_osc);
        rst = 1'b0;
        expect_period(80, 1'b0, 1, "R3");

        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                #1000000;
                checks++;
                failures++;
                $display("FAIL watchdog expired actual=hung expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule